// File: doc/BRIEF.md
# Sine/Cosine Numerically Controlled Oscillator Core

This core turns a running phase into a stream of signed samples for a digital-to-analog converter, one sample per system clock. A 32-bit phase register advances by a programmable frequency word on every clock. Its upper 19 bits are offset by a 16-bit phase word and converted to sine or cosine by a fully pipelined CORDIC rotator, which needs no stored waveform. The result is then scaled by a 14-bit amplitude word and rounded down to a 14-bit two's-complement sample.

The frequency, phase and amplitude words, together with the sine/cosine choice, are captured as one set on a load strobe. A mix of old and new settings therefore never reaches the output. A separate synchronous clear returns the phase register to zero without touching the settings. A valid flag shows when the pipeline holds samples that were computed after reset.

Top module: `nco_sinegen`

## Requirements
- R1: The phase register is 32 bits wide. Except under reset or clear, it grows by the latched frequency word on every clock, modulo 2^32. Only its top 19 bits drive the conversion, so a frequency word of 2^k gives an output sequence that repeats exactly every 2^(32-k) clocks.
- R2: With `acc_clr` high at a clock edge, the phase register is zero after that edge. The latched settings are left as they were.
- R3: The conversion phase is (phase[31:13] + 8·phase_ofs) mod 2^19. One step of `phase_ofs` is 360/2^16 degrees, and 2^19 stands for a full turn.
- R4: With the latched `cos_sel` at 0 the core produces sin(θ). With it at 1 the core produces cos(θ), which is the same phase moved forward by a quarter turn (2^17 of the 19-bit phase).
- R5: The sample equals 8175.14·(amp_scale/2^14)·f(θ) to within ±2 LSB, where f is the selected sine or cosine. It is two's-complement, and an amplitude word of 0 gives 0.
- R6: Frequency words at or above 2^31 are used unchanged, with no clamping. They run the phase backwards and give the aliased tone (1 − F/2^32)·fclk.
- R7: For every input, the sample stays within ±8191 and never takes the value −8192.
- R8: `freq_word`, `phase_ofs`, `amp_scale` and `cos_sel` are captured together at a clock edge where `load` is high. They act from the next clock onward. A change on these inputs without `load` has no effect on the output.
- R9: The sample shows the phase state and the settings that were in force 19 clocks earlier. `sample_vld` goes high after the 19th clock edge with `rst` low, and stays high until the next reset.
- R10: While `rst` is high, and until `sample_vld` rises, `sample` is 0 and `sample_vld` is 0. Reset also clears the phase register and all the settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures the four setting inputs as one set |
| freq_word | input | 32 | Phase increment per clock |
| phase_ofs | input | 16 | Phase offset added to the top of the phase |
| amp_scale | input | 14 | Unsigned amplitude gain, full scale at 2^14 |
| cos_sel | input | 1 | 0 selects sine, 1 selects cosine |
| acc_clr | input | 1 | Synchronous clear of the phase register |
| sample | output | 14 | Two's-complement output sample |
| sample_vld | output | 1 | High once the pipeline holds post-reset samples |

## Verification
The bench drives the phase offset to the four quadrant points and to off-axis values. Every quadrant of the fold is covered, so a mistake in the fold would show up as a sign error or a mirrored waveform. It runs frequency words at 2^31 and above, where a design that clamped or saturated would lose the reversed phase, and it checks exact repetition over 256 clocks, which would expose a phase register that is too narrow or a wrong tap. It also pulses and holds the clear, changes the settings without a load strobe, and drives the amplitude at full scale to check that the peak never wraps to −8192. An error of one clock in the latency would show as a mismatch against the delayed reference on every cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Angle units inside the rotator: 2^ANG_W counts equal one full turn.
  localparam int ANG_W = 24;

  // Number of entries available in the arctangent function below.
  localparam int MAX_ITER = 18;

  // Start value for the x leg of a 20-bit rotator running 16 rotations.
  // After the gain of about 1.64676 the vector length is about 130802,
  // which is 16 * 8175.14 at the output scale.
  localparam int ROT_SEED = 79430;

  // atan(2^-k) expressed in units of 2^-24 turn.
  function automatic logic [ANG_W-1:0] atan_lut(input int k);
    case (k)
      0:       return 24'd2097152;
      1:       return 24'd1238021;
      2:       return 24'd654136;
      3:       return 24'd332050;
      4:       return 24'd166669;
      5:       return 24'd83416;
      6:       return 24'd41718;
      7:       return 24'd20860;
      8:       return 24'd10430;
      9:       return 24'd5215;
      10:      return 24'd2608;
      11:      return 24'd1304;
      12:      return 24'd652;
      13:      return 24'd326;
      14:      return 24'd163;
      15:      return 24'd81;
      16:      return 24'd41;
      17:      return 24'd20;
      default: return 24'd0;
    endcase
  endfunction

endpackage

// File: rtl/nco_param_bank.sv
module nco_param_bank #(
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] freq_in,
  input  logic [PW-1:0] ofs_in,
  input  logic [AW-1:0] amp_in,
  input  logic          csel_in,
  output logic [FW-1:0] freq_q,
  output logic [PW-1:0] ofs_q,
  output logic [AW-1:0] amp_q,
  output logic          csel_q
);

  // All four settings move on the same edge, so no mixed set is ever seen.
  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
      ofs_q  <= '0;
      amp_q  <= '0;
      csel_q <= 1'b0;
    end else if (load) begin
      freq_q <= freq_in;
      ofs_q  <= ofs_in;
      amp_q  <= amp_in;
      csel_q <= csel_in;
    end
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FW   = 32,
  parameter int PW   = 16,
  parameter int AW   = 14,
  parameter int PH_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_clr,
  input  logic [FW-1:0]   freq,
  input  logic [PW-1:0]   ofs,
  input  logic [AW-1:0]   amp,
  input  logic            csel,
  output logic [FW-1:0]   acc_o,
  output logic [PH_W-1:0] ph_o,
  output logic [AW-1:0]   amp_o,
  output logic            vld_o
);

  localparam int OFS_SH = PH_W - PW;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic [PH_W-1:0] ofs_al;
  logic [PH_W-1:0] ofs_tot;

  // The offset word sits on the top bits of the truncated phase.
  assign ofs_al = {ofs, {OFS_SH{1'b0}}};

  // Cosine is sine advanced by a quarter turn.
  always_comb begin
    ofs_tot = ofs_al + (csel ? QUARTER : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      ph_o  <= '0;
      amp_o <= '0;
      vld_o <= 1'b0;
    end else begin
      acc_o <= acc_clr ? '0 : acc_o + freq;
      ph_o  <= acc_o[FW-1 -: PH_W] + ofs_tot;
      amp_o <= amp;
      vld_o <= 1'b1;
    end
  end

endmodule

// File: rtl/nco_cordic.sv
module nco_cordic #(
  parameter int PH_W = 19,
  parameter int DW   = 20,
  parameter int AW   = 14,
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PH_W-1:0]      ph_i,
  input  logic [AW-1:0]        amp_i,
  input  logic                 vld_i,
  output logic signed [DW-1:0] y_o,
  output logic                 neg_o,
  output logic [AW-1:0]        amp_o,
  output logic                 vld_o
);

  localparam int ZW   = nco_pkg::ANG_W;
  localparam int ZPAD = ZW - PH_W;
  localparam logic signed [DW-1:0] SEED = DW'(nco_pkg::ROT_SEED);

  // Element 0 holds the folded start vector; element k+1 holds the result of rotation k.
  logic signed [DW-1:0] xs  [0:ITER];
  logic signed [DW-1:0] ys  [0:ITER];
  logic signed [ZW-1:0] zs  [0:ITER];
  logic                 ngs [0:ITER];
  logic [AW-1:0]        ams [0:ITER];
  logic                 vls [0:ITER];

  // Phases in the second and third quadrants are moved by half a turn and
  // the result is negated, so the rotator only ever sees [-90, +90) degrees.
  logic          fold;
  logic [ZW-1:0] z_start;

  assign fold    = ph_i[PH_W-1] ^ ph_i[PH_W-2];
  assign z_start = {ph_i[PH_W-1] ^ fold, ph_i[PH_W-2:0], {ZPAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= ITER; k++) begin
        xs[k]  <= '0;
        ys[k]  <= '0;
        zs[k]  <= '0;
        ngs[k] <= 1'b0;
        ams[k] <= '0;
        vls[k] <= 1'b0;
      end
    end else begin
      xs[0]  <= SEED;
      ys[0]  <= '0;
      zs[0]  <= $signed(z_start);
      ngs[0] <= fold;
      ams[0] <= amp_i;
      vls[0] <= vld_i;
      for (int k = 0; k < ITER; k++) begin
        if (!zs[k][ZW-1]) begin
          xs[k+1] <= xs[k] - (ys[k] >>> k);
          ys[k+1] <= ys[k] + (xs[k] >>> k);
          zs[k+1] <= zs[k] - $signed(nco_pkg::atan_lut(k));
        end else begin
          xs[k+1] <= xs[k] + (ys[k] >>> k);
          ys[k+1] <= ys[k] - (xs[k] >>> k);
          zs[k+1] <= zs[k] + $signed(nco_pkg::atan_lut(k));
        end
        ngs[k+1] <= ngs[k];
        ams[k+1] <= ams[k];
        vls[k+1] <= vls[k];
      end
    end
  end

  assign y_o   = ys[ITER];
  assign neg_o = ngs[ITER];
  assign amp_o = ams[ITER];
  assign vld_o = vls[ITER];

endmodule

// File: rtl/nco_scale.sv
module nco_scale #(
  parameter int DW = 20,
  parameter int AW = 14,
  parameter int OW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] y_i,
  input  logic                 neg_i,
  input  logic [AW-1:0]        amp_i,
  input  logic                 vld_i,
  output logic signed [OW-1:0] sample_o,
  output logic                 vld_o
);

  localparam int PRW = DW + AW + 1;
  // The rotator carries two guard bits; the amplitude word carries AW fraction bits.
  localparam int SH  = DW - 2;

  logic signed [DW-1:0]  y_s;
  logic signed [PRW-1:0] y_ext;
  logic signed [PRW-1:0] a_ext;
  logic signed [PRW-1:0] prod;

  assign y_s   = neg_i ? -y_i : y_i;
  assign y_ext = {{(AW+1){y_s[DW-1]}}, y_s};
  assign a_ext = {{(DW+1){1'b0}}, amp_i};
  assign prod  = y_ext * a_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      sample_o <= prod[SH+OW-1:SH];
      vld_o    <= vld_i;
    end
  end

endmodule

// File: rtl/nco_sinegen.sv
module nco_sinegen #(
  parameter int FW   = 32,
  parameter int PW   = 16,
  parameter int AW   = 14,
  parameter int PH_W = 19,
  parameter int DW   = 20,
  parameter int ITER = 16,
  parameter int OW   = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [FW-1:0]        freq_word,
  input  logic [PW-1:0]        phase_ofs,
  input  logic [AW-1:0]        amp_scale,
  input  logic                 cos_sel,
  input  logic                 acc_clr,
  output logic signed [OW-1:0] sample,
  output logic                 sample_vld
);

  // One register for the phase sum, one for the fold, ITER rotations, one for scaling.
  localparam int LAT = ITER + 3;

  logic [FW-1:0]        freq_q;
  logic [PW-1:0]        ofs_q;
  logic [AW-1:0]        amp_q;
  logic                 csel_q;
  logic [FW-1:0]        acc_q;
  logic [PH_W-1:0]      ph_p;
  logic [AW-1:0]        amp_p;
  logic                 vld_p;
  logic signed [DW-1:0] y_r;
  logic                 neg_r;
  logic [AW-1:0]        amp_r;
  logic                 vld_r;

  nco_param_bank #(.FW(FW), .PW(PW), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .freq_in (freq_word),
    .ofs_in  (phase_ofs),
    .amp_in  (amp_scale),
    .csel_in (cos_sel),
    .freq_q  (freq_q),
    .ofs_q   (ofs_q),
    .amp_q   (amp_q),
    .csel_q  (csel_q)
  );

  nco_phase_acc #(.FW(FW), .PW(PW), .AW(AW), .PH_W(PH_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .acc_clr (acc_clr),
    .freq    (freq_q),
    .ofs     (ofs_q),
    .amp     (amp_q),
    .csel    (csel_q),
    .acc_o   (acc_q),
    .ph_o    (ph_p),
    .amp_o   (amp_p),
    .vld_o   (vld_p)
  );

  nco_cordic #(.PH_W(PH_W), .DW(DW), .AW(AW), .ITER(ITER)) u_rot (
    .clk   (clk),
    .rst   (rst),
    .ph_i  (ph_p),
    .amp_i (amp_p),
    .vld_i (vld_p),
    .y_o   (y_r),
    .neg_o (neg_r),
    .amp_o (amp_r),
    .vld_o (vld_r)
  );

  nco_scale #(.DW(DW), .AW(AW), .OW(OW)) u_scl (
    .clk      (clk),
    .rst      (rst),
    .y_i      (y_r),
    .neg_i    (neg_r),
    .amp_i    (amp_r),
    .vld_i    (vld_r),
    .sample_o (sample),
    .vld_o    (sample_vld)
  );

endmodule

// File: rtl/nco_sinegen_chk.sv
module nco_sinegen_chk #(
  parameter int FW  = 32,
  parameter int PW  = 16,
  parameter int AW  = 14,
  parameter int OW  = 14,
  parameter int LAT = 19
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load,
  input logic                 acc_clr,
  input logic [FW-1:0]        freq_q,
  input logic [PW-1:0]        ofs_q,
  input logic [AW-1:0]        amp_q,
  input logic                 csel_q,
  input logic [FW-1:0]        acc_q,
  input logic signed [OW-1:0] sample,
  input logic                 sample_vld
);

  localparam int CW = $clog2(LAT + 1);

  // Counts clock edges since reset, saturating at the pipeline depth.
  logic [CW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (fill_cnt != CW'(LAT)) fill_cnt <= fill_cnt + 1'b1;
  end

  // R2: a clear leaves the phase register at zero.
  a_r2_acc_clear: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (acc_q == '0));

  // R8: without a load strobe the settings do not move.
  a_r8_hold_no_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(freq_q) && $stable(ofs_q) && $stable(amp_q) && $stable(csel_q)));

  // R7: the most negative code never appears.
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> (sample != {1'b1, {(OW-1){1'b0}}}));

  // R9: valid rises exactly when the pipeline has filled.
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    sample_vld == (fill_cnt == CW'(LAT)));

  // R9: valid stays high once it has risen.
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> sample_vld);

  // R10: nothing but zero leaves the core before valid.
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |-> (sample == '0));

endmodule

bind nco_sinegen nco_sinegen_chk #(
  .FW(FW), .PW(PW), .AW(AW), .OW(OW), .LAT(LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .acc_clr    (acc_clr),
  .freq_q     (freq_q),
  .ofs_q      (ofs_q),
  .amp_q      (amp_q),
  .csel_q     (csel_q),
  .acc_q      (acc_q),
  .sample     (sample),
  .sample_vld (sample_vld)
);

// File: tb/sim_nco_sinegen.sv
module sim_nco_sinegen;

  localparam int  LAT  = 19;
  localparam real GAIN = 8175.14;
  localparam real TWOPI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic cos_sel = 1'b0;
  logic acc_clr = 1'b0;
  logic [31:0] freq_word = '0;
  logic [15:0] phase_ofs = '0;
  logic [13:0] amp_scale = '0;
  logic signed [13:0] sample;
  logic sample_vld;

  always #5 clk = ~clk;

  nco_sinegen u0 (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .freq_word  (freq_word),
    .phase_ofs  (phase_ofs),
    .amp_scale  (amp_scale),
    .cos_sel    (cos_sel),
    .acc_clr    (acc_clr),
    .sample     (sample),
    .sample_vld (sample_vld)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  // Behavioural model state, as it stands after the last clock edge.
  logic [31:0] m_acc = '0;
  logic [31:0] m_frq = '0;
  logic [15:0] m_ofs = '0;
  logic [13:0] m_amp = '0;
  bit          m_cos = 1'b0;
  int          nrst_edges = 0;
  real         exp_q[$];
  string       tag_q[$];
  int          hist[0:511];

  function automatic real model_value();
    int unsigned ph;
    ph = ((int'(m_acc >> 13)) + (int'(m_ofs) * 8) + (m_cos ? 131072 : 0)) % 524288;
    return GAIN * $sin(TWOPI * real'(ph) / 524288.0) * real'(m_amp) / 16384.0;
  endfunction

  task automatic chk_near(string tag, real e, int a);
    n_run++;
    if ((real'(a) - e > 2.0) || (e - real'(a) > 2.0)) begin
      n_fail++;
      $display("FAIL %s: sample=%0d expected=%f", tag, a, e);
    end
  endtask

  task automatic chk_eq(string tag, int a, int e);
    n_run++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // Reference pipeline: compare with the value computed LAT clocks ago, then advance.
  always @(negedge clk) begin
    real   e;
    string t;
    exp_q.push_back(model_value());
    tag_q.push_back(cur_req);
    if (exp_q.size() > LAT) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (sample_vld) begin
        chk_near(t, e, int'(sample));
        chk_eq("R7 range", (sample == -14'sd8192) ? 1 : 0, 0);
      end
    end
    if (!rst) chk_eq("R9 valid", int'(sample_vld), (nrst_edges >= LAT) ? 1 : 0);
    if (rst) begin
      m_acc = '0; m_frq = '0; m_ofs = '0; m_amp = '0; m_cos = 1'b0;
      nrst_edges = 0;
    end else begin
      m_acc = acc_clr ? 32'd0 : m_acc + m_frq;
      if (load) begin
        m_frq = freq_word; m_ofs = phase_ofs; m_amp = amp_scale; m_cos = cos_sel;
      end
      nrst_edges++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_par(logic [31:0] f, logic [15:0] p, logic [13:0] a, bit c);
    freq_word = f; phase_ofs = p; amp_scale = a; cos_sel = c;
    load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  initial begin
    tick(4);
    @(negedge clk);
    chk_eq("R10 reset sample", int'(sample), 0);
    chk_eq("R10 reset valid", int'(sample_vld), 0);
    tick(1);
    rst = 1'b0;

    cur_req = "R9";
    tick(LAT + 4);

    // Zero phase, full amplitude: sine near 0, cosine near peak.
    cur_req = "R5";
    set_par(32'd0, 16'd0, 14'd16383, 1'b0);
    tick(LAT + 3);
    @(negedge clk);
    chk_near("R5 zero-phase sine", 0.0, int'(sample));
    cur_req = "R4";
    set_par(32'd0, 16'd0, 14'd16383, 1'b1);
    tick(LAT + 3);
    @(negedge clk);
    chk_near("R4 zero-phase cosine", GAIN * 16383.0 / 16384.0, int'(sample));

    // Phase offset across all quadrants and off-axis points.
    cur_req = "R3";
    set_par(32'd0, 16'd16384, 14'd16383, 1'b0);
    tick(LAT + 3);
    @(negedge clk);
    chk_near("R3 offset 90deg", GAIN * 16383.0 / 16384.0, int'(sample));
    set_par(32'd0, 16'd49152, 14'd16383, 1'b0);
    tick(LAT + 3);
    @(negedge clk);
    chk_near("R3 offset 270deg", -GAIN * 16383.0 / 16384.0, int'(sample));
    for (int k = 0; k < 8; k++) begin
      set_par(32'd0, 16'(k * 9001 + 1234), 14'd16383, k[0]);
      tick(LAT + 2);
    end

    // Amplitude scaling.
    cur_req = "R5";
    set_par(32'd0, 16'd16384, 14'd8192, 1'b0);
    tick(LAT + 3);
    @(negedge clk);
    chk_near("R5 half scale", GAIN * 0.5, int'(sample));
    set_par(32'd0, 16'd16384, 14'd0, 1'b0);
    tick(LAT + 3);
    @(negedge clk);
    chk_eq("R5 zero scale", int'(sample), 0);
    set_par(32'd0, 16'd40000, 14'd12345, 1'b1);
    tick(LAT + 3);
    set_par(32'd0, 16'd16384, 14'd1, 1'b0);
    tick(LAT + 3);

    // Running tone, sine then cosine.
    cur_req = "R4";
    set_par(32'h0123_4567, 16'd0, 14'd16383, 1'b0);
    tick(60);
    set_par(32'h0123_4567, 16'd0, 14'd16383, 1'b1);
    tick(60);

    // Exact period for a power-of-two increment.
    cur_req = "R1";
    set_par(32'h0100_0000, 16'd0, 14'd16383, 1'b0);
    tick(LAT + 4);
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      hist[k] = int'(sample);
    end
    for (int k = 0; k < 256; k += 32) begin
      chk_eq("R1 period 256", hist[k + 256], hist[k]);
      chk_near("R1 half period", -real'(hist[k]), hist[k + 128]);
    end

    // Increments at and above half range are not clamped.
    cur_req = "R6";
    set_par(32'h8000_0000, 16'd16384, 14'd16383, 1'b0);
    tick(40);
    set_par(32'hF000_0000, 16'd0, 14'd16383, 1'b0);
    tick(60);
    set_par(32'hFEDC_BA98, 16'd777, 14'd15000, 1'b1);
    tick(60);

    // Synchronous clear: single pulses and a held clear.
    cur_req = "R2";
    set_par(32'h0345_6789, 16'd0, 14'd16383, 1'b0);
    tick(30);
    acc_clr = 1'b1; tick(1); acc_clr = 1'b0;
    tick(25);
    acc_clr = 1'b1; tick(6); acc_clr = 1'b0;
    tick(LAT + 3);

    // Settings without a load strobe are ignored.
    cur_req = "R8";
    freq_word = 32'h7777_0000; phase_ofs = 16'd5000; amp_scale = 14'd100; cos_sel = 1'b1;
    tick(50);
    set_par(32'h0011_2233, 16'd300, 14'd9000, 1'b0);
    tick(40);

    // Full-scale sweep over many phases.
    cur_req = "R7";
    set_par(32'h0009_3A1F, 16'd0, 14'd16383, 1'b0);
    tick(1500);
    set_par(32'hFFF6_C5E1, 16'd12345, 14'd16383, 1'b1);
    tick(1500);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule